// File: doc/BRIEF.md
# SPI Controller Status and Error Flag Unit

This unit keeps the state word of a serial peripheral controller: an operational-enable bit, a master-select bit and six sticky error flags. The six flags are mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software never writes the state word directly. It writes a strobe word in which every bit has its own set strobe and its own clear strobe. Strobes that are not written leave their bits unchanged, so no read-modify-write sequence is needed.

The shift engine and the FIFOs report faults as single-cycle pulses. A separate control word holds one detection enable for each fault class that can be enabled. A pulse latches its flag only while that class is enabled; mode error has no enable and always latches. One error interrupt line is asserted while any flag is set whose class counts. The state word also carries a read-only busy bit, which follows the shift engine.

Top module: `sspi_status_unit`

## Requirements
- R1: After reset, the state word, the control word and the error interrupt are all 0.
- R2: The strobe word has this map. Bit 0 clears enable and bit 1 sets it. Bit 2 clears master-select and bit 3 sets it. Bit 4 clears receive underflow and bit 5 sets it. Bit 6 clears mode error and bit 7 sets it. Bits 8, 9, 10 and 11 clear transmit overflow, receive overflow, abort and transmit underflow, and bits 12, 13, 14 and 15 set the same four flags in that order. In the state word, enable is at bit 0 and master-select at bit 1. The six flags are at bits 7 to 12 in the order mode error, transmit overflow, receive overflow, abort, transmit underflow, receive underflow. A strobe write takes effect at the clock edge that samples it.
- R3: When a set strobe and its matching clear strobe are written together, the bit keeps its previous value.
- R4: When the strobe-write enable is low, the strobe data has no effect. A bit whose set and clear strobes are both 0 keeps its value.
- R5: A fault pulse sets its flag only while its detection enable is 1. In the control word, bits 8 to 12 enable transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Mode error pulses always set their flag. A pulse on a disabled class leaves its flag unchanged.
- R6: A set flag stays set until a clear strobe, or reset, removes it.
- R7: An enabled fault pulse that arrives in the same cycle as a software clear of that flag leaves the flag set.
- R8: The error interrupt is 1 exactly when at least one flag is set whose class is enabled. Mode error always counts. The interrupt changes at the same edge as the flags and enables it depends on.
- R9: State bit 13 shows the busy input as sampled at the previous clock edge. No strobe changes it. State bits 2 to 6 and 14 and above read 0.
- R10: A control write stores bits 8 to 12 only. All other control-word bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_we | input | 1 | Strobe-word write enable |
| mod_wdata | input | MOD_W (16) | Set/clear strobes |
| ctrl_we | input | 1 | Control-word write enable |
| ctrl_wdata | input | CTRL_W (32) | Control-word data (detection enables) |
| err_pulse | input | 6 | Fault pulses, index 0..5 = mode, tx overflow, rx overflow, abort, tx underflow, rx underflow |
| busy_in | input | 1 | Shift engine busy |
| status_word | output | STS_W (32) | State word |
| ctrl_word | output | CTRL_W (32) | Control word readback |
| err_irq | output | 1 | Error interrupt |

## Verification
Two activities can meet on one flag in the same cycle: a software strobe (set, clear, or both) and a hardware fault pulse, while a control write may change the enable that gates both the pulse and the interrupt. The bench sweeps all 65536 strobe words. In each cycle it pairs the strobe word with pseudo-random fault pulses, control writes and busy values, so every collision happens many times. Each cycle is compared with a bench-side model of the requirements: the pulse wins over a clear, paired strobes hold the bit, and the gate is taken from the enables that held before the edge. Directed steps first isolate each collision and name it.

// File: rtl/sspi_status_pkg.sv
package sspi_status_pkg;
  localparam int NUM_ERR = 6;
  localparam int NUM_EN  = 5;
  localparam int EN_LO   = 8;
  localparam int EN_HI   = EN_LO + NUM_EN - 1;

  // state word positions
  localparam int STS_RUN  = 0;
  localparam int STS_MSEL = 1;
  localparam int STS_BUSY = 13;

  // strobe positions for run and master-select
  localparam int CLR_RUN  = 0;
  localparam int SET_RUN  = 1;
  localparam int CLR_MSEL = 2;
  localparam int SET_MSEL = 3;

  // per fault class: 0 mode, 1 tx ovf, 2 rx ovf, 3 abort, 4 tx und, 5 rx und
  localparam int ERR_STS_BIT [NUM_ERR] = '{7, 8, 9, 10, 11, 12};
  localparam int ERR_CLR_BIT [NUM_ERR] = '{6, 8, 9, 10, 11, 4};
  localparam int ERR_SET_BIT [NUM_ERR] = '{7, 12, 13, 14, 15, 5};
  localparam bit ERR_HAS_EN  [NUM_ERR] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam int ERR_EN_BIT  [NUM_ERR] = '{8, 8, 9, 10, 11, 12};
endpackage

// File: rtl/sspi_flag_cell.sv
module sspi_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_i,
  output logic q_o,
  output logic d_o
);
  always_comb begin
    if (hw_i)                d_o = 1'b1;
    else if (set_i && !clr_i) d_o = 1'b1;
    else if (clr_i && !set_i) d_o = 1'b0;
    else                      d_o = q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_o;
  end

  assert_pair_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i && !hw_i) |=> (q_o == $past(q_o)));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
  assert_pulse_wins_R7: assert property (@(posedge clk) disable iff (rst)
    hw_i |=> q_o);
endmodule

// File: rtl/sspi_err_enable.sv
module sspi_err_enable
  import sspi_status_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [NUM_EN-1:0] en_q,
  output logic [NUM_EN-1:0] en_d,
  output logic [CTRL_W-1:0] ctrl_word
);
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{ctrl_wdata[CTRL_W-1:EN_HI+1], ctrl_wdata[EN_LO-1:0]};

  assign en_d = ctrl_we ? ctrl_wdata[EN_HI:EN_LO] : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_HI:EN_LO] = en_q;
  end

  assert_ctrl_store_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (ctrl_word[EN_HI:EN_LO] == $past(ctrl_wdata[EN_HI:EN_LO])));
  assert_ctrl_keep_R10: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(ctrl_word));
endmodule

// File: rtl/sspi_irq_gen.sv
module sspi_irq_gen
  import sspi_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] flag_d,
  input  logic [NUM_ERR-1:0] count_d,
  output logic               irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_d & count_d);
  end
endmodule

// File: rtl/sspi_status_unit.sv
module sspi_status_unit
  import sspi_status_pkg::*;
#(
  parameter int MOD_W  = 16,
  parameter int CTRL_W = 32,
  parameter int STS_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mod_we,
  input  logic [MOD_W-1:0]   mod_wdata,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic [NUM_ERR-1:0] err_pulse,
  input  logic               busy_in,
  output logic [STS_W-1:0]   status_word,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic               err_irq
);
  logic [MOD_W-1:0]   stb;
  logic [NUM_EN-1:0]  en_q, en_d;
  logic [NUM_ERR-1:0] gate_q, gate_d;
  logic [NUM_ERR-1:0] fl_q, fl_d;
  logic               run_q, run_d, msel_q, msel_d;
  logic               busy_q;

  assign stb = mod_we ? mod_wdata : '0;

  sspi_err_enable #(.CTRL_W(CTRL_W)) u_en (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .en_q(en_q), .en_d(en_d), .ctrl_word(ctrl_word)
  );

  sspi_flag_cell u_run (
    .clk(clk), .rst(rst), .set_i(stb[SET_RUN]), .clr_i(stb[CLR_RUN]),
    .hw_i(1'b0), .q_o(run_q), .d_o(run_d)
  );

  sspi_flag_cell u_msel (
    .clk(clk), .rst(rst), .set_i(stb[SET_MSEL]), .clr_i(stb[CLR_MSEL]),
    .hw_i(1'b0), .q_o(msel_q), .d_o(msel_d)
  );

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
    if (ERR_HAS_EN[k]) begin : g_gated
      assign gate_q[k] = en_q[ERR_EN_BIT[k]-EN_LO];
      assign gate_d[k] = en_d[ERR_EN_BIT[k]-EN_LO];
    end else begin : g_always
      assign gate_q[k] = 1'b1;
      assign gate_d[k] = 1'b1;
    end

    sspi_flag_cell u_cell (
      .clk(clk), .rst(rst),
      .set_i(stb[ERR_SET_BIT[k]]), .clr_i(stb[ERR_CLR_BIT[k]]),
      .hw_i(err_pulse[k] & gate_q[k]),
      .q_o(fl_q[k]), .d_o(fl_d[k])
    );

    assert_masked_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      (!mod_we && !gate_q[k]) |=> (status_word[ERR_STS_BIT[k]] == $past(status_word[ERR_STS_BIT[k]])));
    assert_idle_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      (!mod_we && !err_pulse[k]) |=> $stable(status_word[ERR_STS_BIT[k]]));
  end

  sspi_irq_gen u_irq (
    .clk(clk), .rst(rst), .flag_d(fl_d), .count_d(gate_d), .irq_q(err_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_in;
  end

  always_comb begin
    status_word = '0;
    status_word[STS_RUN]  = run_q;
    status_word[STS_MSEL] = msel_q;
    status_word[STS_BUSY] = busy_q;
    for (int k = 0; k < NUM_ERR; k++) status_word[ERR_STS_BIT[k]] = fl_q[k];
  end

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> (status_word[12:7] != 6'd0));
  assert_busy_follow_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_word[STS_BUSY] == $past(busy_in)));
  assert_run_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !mod_we |=> $stable(status_word[1:0]));
endmodule

// File: tb/sim_sspi_status_unit.sv
module sim_sspi_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_we = 1'b0;
  logic [15:0] mod_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [5:0]  err_pulse = '0;
  logic        busy_in = 1'b0;
  logic [31:0] status_word;
  logic [31:0] ctrl_word;
  logic        err_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sspi_status_unit u0 (
    .clk(clk), .rst(rst), .mod_we(mod_we), .mod_wdata(mod_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .err_pulse(err_pulse),
    .busy_in(busy_in), .status_word(status_word), .ctrl_word(ctrl_word),
    .err_irq(err_irq)
  );

  // bench-side view of the requirements
  int sbit [6] = '{7, 8, 9, 10, 11, 12};
  int cbit [6] = '{6, 8, 9, 10, 11, 4};
  int tbit [6] = '{7, 12, 13, 14, 15, 5};
  bit m_run, m_ms, m_busy;
  bit [5:0] m_fl;
  bit [5:0] m_gate;   // bit 0 (mode) is always 1

  function automatic bit nxt(bit q, bit s, bit c, bit hw);
    if (hw) return 1'b1;
    if (s && !c) return 1'b1;
    if (c && !s) return 1'b0;
    return q;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit mwe, bit [15:0] md, bit cwe, bit [31:0] cd,
                      bit [5:0] hw, bit bsy, string req);
    bit [15:0] s;
    bit [31:0] exp_sts;
    bit [31:0] exp_ctl;
    @(negedge clk);
    mod_we = mwe; mod_wdata = md; ctrl_we = cwe; ctrl_wdata = cd;
    err_pulse = hw; busy_in = bsy;
    s = mwe ? md : 16'h0;
    for (int k = 0; k < 6; k++)
      m_fl[k] = nxt(m_fl[k], s[tbit[k]], s[cbit[k]], hw[k] & m_gate[k]);
    m_run = nxt(m_run, s[1], s[0], 1'b0);
    m_ms  = nxt(m_ms, s[3], s[2], 1'b0);
    if (cwe) m_gate[5:1] = cd[12:8];
    m_busy = bsy;
    @(posedge clk); #1;
    exp_sts = '0;
    exp_sts[0] = m_run; exp_sts[1] = m_ms; exp_sts[13] = m_busy;
    for (int k = 0; k < 6; k++) exp_sts[sbit[k]] = m_fl[k];
    exp_ctl = {19'd0, m_gate[5:1], 8'd0};
    chk(req, {status_word, ctrl_word[31:1], err_irq},
        {exp_sts, exp_ctl[31:1], |(m_fl & m_gate)});
  endtask

  initial begin
    bit [31:0] lf;
    m_run = 0; m_ms = 0; m_busy = 0; m_fl = '0; m_gate = 6'b000001;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", {status_word, ctrl_word, err_irq}, 65'd0);

    // R2: each strobe on its own
    step(1, 16'h0002, 0, 0, 0, 0, "R2 set run");
    step(1, 16'h0008, 0, 0, 0, 0, "R2 set msel");
    step(1, 16'h0001, 0, 0, 0, 0, "R2 clr run");
    step(1, 16'h0004, 0, 0, 0, 0, "R2 clr msel");
    for (int k = 0; k < 6; k++) begin
      step(1, 16'(1 << tbit[k]), 0, 0, 0, 0, "R2 set flag");
      step(1, 16'(1 << cbit[k]), 0, 0, 0, 0, "R2 clr flag");
    end
    // R3: paired strobes hold, from 0 and from 1
    step(1, 16'hFFFF, 0, 0, 0, 0, "R3 pair from zero");
    step(1, 16'hF0AA, 0, 0, 0, 0, "R2 set all");
    step(1, 16'hFFFF, 0, 0, 0, 0, "R3 pair from one");
    // R4: disabled strobe write
    step(0, 16'h0F55, 0, 0, 0, 0, "R4 we low");
    step(1, 16'h0000, 0, 0, 0, 0, "R4 empty strobe");
    step(1, 16'h0F55, 0, 0, 0, 0, "R2 clr all");
    // R5: pulses with enables off: only mode error latches
    step(0, 0, 0, 0, 6'h3F, 0, "R5 masked pulses");
    step(1, 16'h0040, 1, 32'hFFFF_FFFF, 0, 0, "R10 ctrl all ones");
    step(0, 0, 0, 0, 6'h3E, 0, "R5 enabled pulses");
    // R6: sticky
    step(0, 0, 0, 0, 0, 0, "R6 sticky a");
    step(0, 0, 0, 0, 0, 1, "R6 sticky b / R9 busy");
    // R7: pulse with clear in same cycle
    step(1, 16'h0F50, 0, 0, 6'h3F, 1, "R7 pulse beats clear");
    step(1, 16'h0F50, 0, 0, 0, 0, "R7 then clear");
    // R8: software-set flag with class disabled
    step(1, 16'h0000, 1, 32'h0, 0, 0, "R10 ctrl zero");
    step(1, 16'h1000, 0, 0, 0, 0, "R8 gated flag no irq");
    step(0, 0, 1, 32'h0000_0100, 0, 0, "R8 enable raises irq");
    step(0, 0, 1, 32'h0000_0000, 0, 0, "R8 disable drops irq");
    step(1, 16'h0080, 0, 0, 0, 0, "R8 mode error counts");
    // R9: busy unaffected by strobes
    step(1, 16'hFFFF, 0, 0, 0, 1, "R9 busy high");
    step(1, 16'hFFFF, 0, 0, 0, 0, "R9 busy low");

    // sweep of every strobe word with random collisions
    lf = 32'h1234_5679;
    for (int v = 0; v < 65536; v++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      step(lf[0], 16'(v), lf[1] & lf[2], lf, lf[13:8] & lf[19:14], lf[20],
           "R3 R5 R7 R8 sweep");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule